// File: doc/BRIEF.md
# Real-Time Clock Divider and Periodic Rate Generator

This block is the front end of a real-time clock. It counts enables from a 32768 Hz time base in a 15-bit prescaler and delivers two results. The first is a one-cycle seconds strobe for the timekeeping counters. The second is a periodic pulse whose rate is chosen by a 4-bit rate code, and that pulse also sets a sticky interrupt flag. A small register port lets software write and read a control byte. The control byte holds a 3-bit divider field and the rate code. The same port can read a status byte, and that read clears the flag.

The divider field drives a three-state machine. In HOLD, the prescaler is parked at its half-way count. In RUN, it counts time-base enables. In FROZEN, it keeps its count. Every write to the control byte decodes the new divider field into the next state. The transitions are:
- release: HOLD to RUN.
- park: any state to HOLD.
- pause: RUN to FROZEN.
- resume: FROZEN to RUN.
- hold-to-frozen.
- rewrite: writing the same state again.

Because HOLD parks the count at half of full scale, the first seconds strobe after release comes exactly half a second later.

Top module: `rtc_divider_rate`

## Requirements
- R1: After reset, the control byte reads 0x76 (divider 111, rate 0110), the status byte reads 0x00, and `sec_tick`, `per_pulse` and `per_irq` are low.
- R2: While the divider field is 111, no seconds strobe and no periodic pulse is produced, whatever the time-base enable does.
- R3: A write that moves the divider field from 111 to 010 makes the first `sec_tick` fall on the 16384th time-base enable after the write edge. Later strobes come every 32768 enables.
- R4: For a rate code c from 3 to 15, in RUN, `per_pulse` fires once every 2^(c-1) time-base enables. Code 3 is therefore 8192 Hz and code 15 is 2 Hz.
- R5: Rate codes 0001 and 0010 give the same pulse spacing as codes 1000 and 1001 (128 and 256 enables).
- R6: Rate code 0000 produces no periodic pulse.
- R7: Any divider field other than 010 or 111 freezes the prescaler: no strobes and no pulses. A later return to 010 continues from the frozen count.
- R8: A periodic pulse sets a flag that reads as bit 6 of the status byte. A read of the status byte returns the flag and clears it on that edge, unless a new pulse arrives on the same edge, in which case the pulse wins.
- R9: `per_irq` always equals the flag, and it rises only together with `per_pulse`.
- R10: The status byte ignores writes. In the control byte, bits 6:4 hold the divider field, bits 3:0 hold the rate code, and bit 7 reads 0 whatever is written.
- R11: `sec_tick` and `per_pulse` are single-cycle pulses. Each is registered and goes high in the cycle after the clock edge that sampled the time-base enable which caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_tick | input | 1 | One-cycle enable at the 32768 Hz time-base rate |
| reg_sel | input | 1 | Register select: 0 control byte, 1 status byte |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 7 | Write data, bits 6:4 divider field and bits 3:0 rate code |
| rd_en | input | 1 | Read strobe; a status read clears the flag |
| rd_data | output | 8 | Combinational read data of the selected register |
| sec_tick | output | 1 | One-cycle seconds strobe |
| per_pulse | output | 1 | One-cycle periodic pulse |
| per_irq | output | 1 | Level interrupt, equal to the sticky flag |

## Verification
A register write takes effect on the edge that samples it. The prescaler responds to a time-base enable on the following edges, and `sec_tick` and `per_pulse` appear one cycle after the edge that saw their enable. The flag rises on that same edge, so `per_irq` and `per_pulse` go high together. A status read is seen in `rd_data` in the same cycle and clears the flag one edge later. The bench model applies every input at the rising edge and drives inputs on the falling edge. It compares the outputs on the next falling edge, which is one register stage after the cause. Window counts start at the falling edge just after a write edge, so the number of enables they span is exact.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

    localparam int DIV_W  = 3;
    localparam int RATE_W = 4;

    localparam logic [DIV_W-1:0] DIV_CODE_RUN  = 3'b010;
    localparam logic [DIV_W-1:0] DIV_CODE_HOLD = 3'b111;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } div_state_e;

    function automatic div_state_e div_decode(input logic [DIV_W-1:0] field);
        if (field == DIV_CODE_RUN) begin
            return ST_RUN;
        end else if (field == DIV_CODE_HOLD) begin
            return ST_HOLD;
        end
        return ST_FROZEN;
    endfunction

    // Rate codes 1 and 2 borrow the spacing of codes 8 and 9
    function automatic int rate_effective(input int code);
        if (code == 1 || code == 2) begin
            return code + 7;
        end
        return code;
    endfunction

endpackage

// File: rtl/rtc_div_ctrl.sv
module rtc_div_ctrl
    import rtc_div_pkg::*;
#(
    parameter logic [DIV_W-1:0]  RST_DIV  = 3'b111,
    parameter logic [RATE_W-1:0] RST_RATE = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DIV_W-1:0]  wr_div,
    input  logic [RATE_W-1:0] wr_rate,
    output logic [DIV_W-1:0]  div_q,
    output logic [RATE_W-1:0] rate_q,
    output logic              run_en,
    output logic              hold_en
);

    div_state_e state_q;
    div_state_e state_d;

    // Field storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= RST_DIV;
            rate_q <= RST_RATE;
        end else if (wr_ctrl) begin
            div_q  <= wr_div;
            rate_q <= wr_rate;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= div_decode(RST_DIV);
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: release, park, pause, resume, hold-to-frozen, rewrite
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (wr_ctrl) begin
                    state_d = div_decode(wr_div);
                end
            end
            ST_RUN: begin
                if (wr_ctrl) begin
                    state_d = div_decode(wr_div);
                end
            end
            ST_FROZEN: begin
                if (wr_ctrl) begin
                    state_d = div_decode(wr_div);
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // Outputs from state
    always_comb begin
        run_en  = 1'b0;
        hold_en = 1'b0;
        unique case (state_q)
            ST_HOLD:   hold_en = 1'b1;
            ST_RUN:    run_en  = 1'b1;
            ST_FROZEN: begin
                run_en  = 1'b0;
                hold_en = 1'b0;
            end
            default:   hold_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             hold_en,
    input  logic             tb_tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             roll
);

    localparam logic [CNT_W-1:0] HALF_CNT = {1'b1, {(CNT_W-1){1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= HALF_CNT;
        end else if (hold_en) begin
            cnt_q <= HALF_CNT;
        end else if (run_en && tb_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign roll = run_en && tb_tick && (&cnt_q);

endmodule

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap
    import rtc_div_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic              run_en,
    input  logic              tb_tick,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [RATE_W-1:0] rate,
    output logic              hit
);

    localparam int NCODE = 1 << RATE_W;

    logic [NCODE-1:0] code_hit;

    for (genvar g = 0; g < NCODE; g++) begin : g_code
        localparam int EFF = rate_effective(g);
        if (EFF == 0 || EFF > CNT_W) begin : g_off
            assign code_hit[g] = 1'b0;
        end else begin : g_on
            localparam logic [CNT_W-1:0] MASK = CNT_W'((1 << (EFF - 1)) - 1);
            assign code_hit[g] = ((cnt & MASK) == MASK);
        end
    end

    assign hit = run_en && tb_tick && code_hit[rate];

endmodule

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_divider_rate.sv
module rtc_divider_rate
    import rtc_div_pkg::*;
#(
    parameter int                CNT_W    = 15,
    parameter logic [DIV_W-1:0]  RST_DIV  = 3'b111,
    parameter logic [RATE_W-1:0] RST_RATE = 4'b0110
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tb_tick,
    input  logic       reg_sel,
    input  logic       wr_en,
    input  logic [6:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       sec_tick,
    output logic       per_pulse,
    output logic       per_irq
);

    localparam int FLAG_BIT = 6;

    logic [DIV_W-1:0]  div_q;
    logic [RATE_W-1:0] rate_q;
    logic              run_en;
    logic              hold_en;
    logic [CNT_W-1:0]  cnt;
    logic              roll;
    logic              hit;
    logic              flag;
    logic              wr_ctrl;
    logic              rd_stat;

    assign wr_ctrl = wr_en && !reg_sel;
    assign rd_stat = rd_en && reg_sel;

    rtc_div_ctrl #(
        .RST_DIV  (RST_DIV),
        .RST_RATE (RST_RATE)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_div  (wr_data[6:4]),
        .wr_rate (wr_data[3:0]),
        .div_q   (div_q),
        .rate_q  (rate_q),
        .run_en  (run_en),
        .hold_en (hold_en)
    );

    rtc_prescaler #(
        .CNT_W (CNT_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .hold_en (hold_en),
        .tb_tick (tb_tick),
        .cnt_q   (cnt),
        .roll    (roll)
    );

    rtc_rate_tap #(
        .CNT_W (CNT_W)
    ) u_tap (
        .run_en  (run_en),
        .tb_tick (tb_tick),
        .cnt     (cnt),
        .rate    (rate_q),
        .hit     (hit)
    );

    rtc_irq_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (hit),
        .clr   (rd_stat),
        .flag  (flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_tick  <= 1'b0;
            per_pulse <= 1'b0;
        end else begin
            sec_tick  <= roll;
            per_pulse <= hit;
        end
    end

    always_comb begin
        rd_data = '0;
        if (reg_sel) begin
            rd_data[FLAG_BIT] = flag;
        end else begin
            rd_data[6:4] = div_q;
            rd_data[3:0] = rate_q;
        end
    end

    assign per_irq = flag;

endmodule

// File: rtl/rtc_divider_rate_chk.sv
module rtc_divider_rate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tb_tick,
    input logic       reg_sel,
    input logic       rd_en,
    input logic       sec_tick,
    input logic       per_pulse,
    input logic       per_irq,
    input logic [2:0] div_f,
    input logic [3:0] rate_f
);

    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (div_f == 3'b111) |=> (!sec_tick && !per_pulse)); // R2

    AST_SEC_FROM_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_tick) |-> $past(tb_tick)); // R3

    AST_RATE_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_f == 4'd0) |=> !per_pulse); // R6

    AST_FROZEN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (div_f != 3'b010 && div_f != 3'b111) |=> (!sec_tick && !per_pulse)); // R7

    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        per_pulse |-> per_irq); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel) |=> (!per_irq || per_pulse)); // R8

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_irq) |-> per_pulse); // R9

    AST_SEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick); // R11

    AST_PER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        per_pulse |=> !per_pulse); // R11

endmodule

bind rtc_divider_rate rtc_divider_rate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tb_tick   (tb_tick),
    .reg_sel   (reg_sel),
    .rd_en     (rd_en),
    .sec_tick  (sec_tick),
    .per_pulse (per_pulse),
    .per_irq   (per_irq),
    .div_f     (div_q),
    .rate_f    (rate_q)
);

// File: tb/rtc_divider_rate_tb.sv
module rtc_divider_rate_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_tick = 1'b0;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       sec_tick;
    logic       per_pulse;
    logic       per_irq;

    int total = 0;
    int bad = 0;
    int tb_mode = 0;   // 0 every cycle, 1 every third cycle, 2 off
    int tb_phase = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    // reference model state
    int    m_state, m_cnt, m_div, m_rate, m_flag;
    int    exp_sec = 0, exp_per = 0;
    string per_req = "R4";

    always #2 clk = ~clk;

    rtc_divider_rate dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tb_tick   (tb_tick),
        .reg_sel   (reg_sel),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .sec_tick  (sec_tick),
        .per_pulse (per_pulse),
        .per_irq   (per_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int eff_of(input int code);
        if (code == 1) return 8;
        if (code == 2) return 9;
        return code;
    endfunction

    // time-base enable generator
    always @(negedge clk) begin
        tb_phase <= (tb_phase + 1) % 3;
        case (tb_mode)
            0: tb_tick <= 1'b1;
            1: tb_tick <= (tb_phase == 0);
            default: tb_tick <= 1'b0;
        endcase
    end

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 7; m_rate = 6; m_state = 0; m_cnt = 16384; m_flag = 0;
            exp_sec = 0; exp_per = 0;
        end else begin
            int e;
            e = eff_of(m_rate);
            per_req = (m_rate == 0) ? "R6" : ((m_rate == 1 || m_rate == 2) ? "R5" : "R4");
            exp_sec = (m_state == 1 && tb_tick && m_cnt == 32767) ? 1 : 0;
            exp_per = (m_state == 1 && tb_tick && e != 0 && ((m_cnt + 1) % (1 << (e - 1))) == 0) ? 1 : 0;
            if (exp_per == 1) m_flag = 1;
            else if (rd_en && reg_sel) m_flag = 0;
            if (m_state == 0) m_cnt = 16384;
            else if (m_state == 1 && tb_tick) m_cnt = (m_cnt + 1) % 32768;
            if (wr_en && !reg_sel) begin
                m_div = int'(wr_data[6:4]);
                m_rate = int'(wr_data[3:0]);
                m_state = (m_div == 2) ? 1 : ((m_div == 7) ? 0 : 2);
            end
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk(sec_tick == exp_sec[0], "R3", int'(sec_tick), exp_sec, "sec_tick vs model");
            chk(per_pulse == exp_per[0], per_req, int'(per_pulse), exp_per, "per_pulse vs model");
            chk(per_irq == m_flag[0], "R9", int'(per_irq), m_flag, "per_irq vs model flag");
        end
    end

    task automatic write_reg(input bit sel, input logic [6:0] d);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic read_reg(input bit sel, output logic [7:0] v);
        reg_sel = sel; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic count_window(input int steps, output int ns, output int np);
        ns = 0; np = 0;
        for (int k = 0; k < steps; k++) begin
            @(negedge clk);
            ns += int'(sec_tick);
            np += int'(per_pulse);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int ns, np, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!sec_tick && !per_pulse && !per_irq, "R1", int'(per_irq), 0, "outputs after reset");
        read_reg(1'b0, v);
        chk(v == 8'h76, "R1", int'(v), 'h76, "control byte after reset");
        read_reg(1'b1, v);
        chk(v == 8'h00, "R1", int'(v), 0, "status byte after reset");

        // R2 held divider
        count_window(60, ns, np);
        chk(ns == 0 && np == 0, "R2", ns + np, 0, "pulses while held");

        // R4 fastest rate
        write_reg(1'b0, 7'h23);
        count_window(40, ns, np);
        chk(np == 10, "R4", np, 10, "rate 3 pulses in 40 enables");

        // R7 freeze then resume
        write_reg(1'b0, 7'h03);
        count_window(30, ns, np);
        chk(np == 0 && ns == 0, "R7", np, 0, "pulses while frozen");
        write_reg(1'b0, 7'h23);
        count_window(40, ns, np);
        chk(np == 10, "R7", np, 10, "pulses after resume");

        // R8 and R9 flag read and clear
        tb_mode = 2;
        repeat (3) @(negedge clk);
        chk(per_irq == 1'b1, "R9", int'(per_irq), 1, "irq set after pulses");
        read_reg(1'b1, v);
        chk(v == 8'h40, "R8", int'(v), 'h40, "status read with flag");
        read_reg(1'b1, v);
        chk(v == 8'h00, "R8", int'(v), 0, "status read after clear");
        chk(per_irq == 1'b0, "R9", int'(per_irq), 0, "irq after clear");

        // R10 status write ignored, bit 7 of control reads 0
        write_reg(1'b1, 7'h7F);
        repeat (2) @(negedge clk);
        read_reg(1'b1, v);
        chk(v == 8'h00, "R10", int'(v), 0, "status after write attempt");
        chk(per_irq == 1'b0, "R10", int'(per_irq), 0, "irq after status write");
        write_reg(1'b0, 7'h25);
        read_reg(1'b0, v);
        chk(v == 8'h25, "R10", int'(v), 'h25, "control readback");

        // R5 aliases, enables every third cycle
        tb_mode = 1;
        write_reg(1'b0, 7'h21);
        count_window(1152, ns, np);
        chk(np == 3, "R5", np, 3, "code 1 pulses over 384 enables");
        write_reg(1'b0, 7'h28);
        count_window(1152, ns, np);
        chk(np == 3, "R5", np, 3, "code 8 pulses over 384 enables");
        write_reg(1'b0, 7'h22);
        count_window(2304, ns, np);
        chk(np == 3, "R5", np, 3, "code 2 pulses over 768 enables");

        // R6 rate off
        tb_mode = 0;
        write_reg(1'b0, 7'h20);
        count_window(200, ns, np);
        chk(np == 0, "R6", np, 0, "pulses with rate 0");

        // R3 half second after release
        write_reg(1'b0, 7'h76);
        @(negedge clk);
        write_reg(1'b0, 7'h26);
        k = 0;
        while (!sec_tick && k < 20000) begin
            @(negedge clk);
            k++;
        end
        chk(k == 16384, "R3", k, 16384, "enables to first seconds strobe");
        @(negedge clk);
        chk(sec_tick == 1'b0, "R11", int'(sec_tick), 0, "seconds strobe width");
        k = 1;
        while (!sec_tick && k < 40000) begin
            @(negedge clk);
            k++;
        end
        chk(k == 32768, "R3", k, 32768, "enables between seconds strobes");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule